// File: doc/BRIEF.md
# Triggered DMA Burst Request Generator with Overrun Detection

This block is one request-generator channel. It watches a trigger line. When it sees a qualified edge, it raises a DMA request and holds it until the DMA controller has acknowledged a programmed number of transfers. Edges are qualified by a glitch filter and by a polarity choice. Edges are also ignored for a short window around every control write.

A trigger that arrives while a burst is still waiting for acknowledges does not restart the burst. Instead it sets a sticky overrun flag. Software clears that flag by writing one to a clear bit. The flag, gated by an interrupt enable, drives one of two interrupt lines. A per-channel security input selects which line is used.

Control fields are loaded on a write strobe. The request-count field should only be changed while the channel is disabled. The hardware does not enforce this rule.

Top module: `dma_trig_reqgen`

## Requirements
- R1: A change of the trigger level counts as an edge only after the new level has been sampled on three consecutive clock edges. The request rises on the fourth clock edge after the trigger changes. A pulse lasting two cycles produces nothing.
- R2: The polarity field `ctrl_pol_i` selects which edges count: 2'b00 none, 2'b01 rising, 2'b10 falling, 2'b11 both.
- R3: A qualified edge is dropped if it would take effect in the cycle of a control write or in any of the three cycles after that write.
- R4: An accepted trigger loads the count N from `ctrl_cnt_i` and starts a burst. `dma_req_o` stays high until N+1 cycles with `dma_ack_i` high have been counted. It falls on the clock edge that registers the final acknowledge.
- R5: A qualified trigger that arrives while `dma_req_o` is high sets the overrun flag. It leaves the running burst unchanged. If the DMA stops acknowledging, the next trigger therefore always causes an overrun.
- R6: The overrun flag is sticky. It is cleared only by a cycle with `clr_we_i` and `clr_ovr_i` both high. If a clear and a new overrun fall in the same cycle, the flag ends up set.
- R7: The interrupt is active while the flag is set and `ctrl_ovr_ie_i` was written as 1. It appears on `irq_sec_o` when `chan_secure_i` is 1 and on `irq_nsec_o` otherwise, and never on both.
- R8: A control write with enable 0 drops the request on the next clock edge and resets the counter. It leaves the overrun flag unchanged.
- R9: While the channel is disabled, trigger edges start no burst and set no flag.
- R10: After reset the request, the flag and both interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we_i | input | 1 | Control write strobe |
| ctrl_en_i | input | 1 | Channel enable value to write |
| ctrl_cnt_i | input | CNT_W | Request count value (N gives N+1 requests) |
| ctrl_pol_i | input | 2 | Trigger polarity value to write |
| ctrl_ovr_ie_i | input | 1 | Overrun interrupt enable value to write |
| clr_we_i | input | 1 | Clear register write strobe |
| clr_ovr_i | input | 1 | Write-one-to-clear bit for the overrun flag |
| chan_secure_i | input | 1 | Channel security attribute |
| trig_i | input | 1 | Trigger input level |
| dma_req_o | output | 1 | DMA request |
| dma_ack_i | input | 1 | DMA acknowledge, one transfer per high cycle |
| ovr_flag_o | output | 1 | Overrun status flag |
| irq_sec_o | output | 1 | Overrun interrupt, secure line |
| irq_nsec_o | output | 1 | Overrun interrupt, non-secure line |

## Verification
Some properties are checked by assertions on every cycle:
- the flag stays set until a clear arrives;
- a new flag always coincides with a pending request;
- the request falls only on an acknowledge or a control write;
- a disabling write removes the request;
- no burst starts right after a write or while disabled;
- the two interrupt lines are never active together.

Other behaviours can only be shown by the bench's scenarios:
- the exact filter latency and the rejection of short pulses;
- each polarity encoding;
- the exact edge of the masking window;
- the count of N+1 acknowledges;
- the outcome when a clear and a set collide;
- interrupt routing by security attribute.

// File: rtl/reqgen_pkg.sv
package reqgen_pkg;
   typedef enum logic [1:0] {
      POL_NONE = 2'b00,
      POL_RISE = 2'b01,
      POL_FALL = 2'b10,
      POL_BOTH = 2'b11
   } trig_pol_e;

   typedef struct packed {
      logic      en;
      logic      ovr_ie;
      trig_pol_e pol;
   } ctrl_bits_t;
endpackage

// File: rtl/rg_edge_filter.sv
module rg_edge_filter #(
   parameter int SYNC_STAGES = 0,
   parameter int HOLD_CYC    = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic rise_o,
   output logic fall_o
);
   localparam int HCW = $clog2(HOLD_CYC + 1);
   localparam logic [HCW-1:0] HOLD_LAST = HCW'(HOLD_CYC - 1);

   if (HOLD_CYC < 1) begin : g_bad_hold
      $error("rg_edge_filter: HOLD_CYC must be at least 1");
   end
   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("rg_edge_filter: SYNC_STAGES must not be negative");
   end

   logic lvl_s;

   if (SYNC_STAGES > 0) begin : g_sync
      logic [SYNC_STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= {chain_q[SYNC_STAGES-2+1-1:0], lvl_i} ;
      end
      assign lvl_s = chain_q[SYNC_STAGES-1];
   end else begin : g_direct
      assign lvl_s = lvl_i;
   end

   logic           acc_q;
   logic [HCW-1:0] run_q;
   logic           rise_q, fall_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= 1'b0;
         run_q  <= '0;
         rise_q <= 1'b0;
         fall_q <= 1'b0;
      end else begin
         rise_q <= 1'b0;
         fall_q <= 1'b0;
         if (lvl_s != acc_q) begin
            if (run_q == HOLD_LAST) begin
               acc_q  <= lvl_s;
               run_q  <= '0;
               rise_q <= lvl_s;
               fall_q <= ~lvl_s;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end else begin
            run_q <= '0;
         end
      end
   end

   assign rise_o = rise_q;
   assign fall_o = fall_q;
endmodule

// File: rtl/rg_trig_gate.sv
module rg_trig_gate
   import reqgen_pkg::*;
#(
   parameter int MASK_CYC = 3
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      ctrl_we_i,
   input  logic      en_i,
   input  trig_pol_e pol_i,
   input  logic      rise_i,
   input  logic      fall_i,
   output logic      trig_o
);
   localparam int MCW = (MASK_CYC < 1) ? 1 : $clog2(MASK_CYC + 1);

   if (MASK_CYC < 0) begin : g_bad_mask
      $error("rg_trig_gate: MASK_CYC must not be negative");
   end

   logic masked;

   if (MASK_CYC > 0) begin : g_mask
      logic [MCW-1:0] mask_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             mask_q <= '0;
         else if (ctrl_we_i)     mask_q <= MCW'(MASK_CYC);
         else if (mask_q != '0)  mask_q <= mask_q - 1'b1;
      end
      assign masked = ctrl_we_i | (mask_q != '0);
   end else begin : g_nomask
      assign masked = ctrl_we_i;
   end

   logic pol_hit;
   always_comb begin
      unique case (pol_i)
         POL_RISE: pol_hit = rise_i;
         POL_FALL: pol_hit = fall_i;
         POL_BOTH: pol_hit = rise_i | fall_i;
         default:  pol_hit = 1'b0;
      endcase
   end

   assign trig_o = pol_hit & en_i & ~masked;
endmodule

// File: rtl/rg_burst_ctr.sv
module rg_burst_ctr #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             kill_i,
   input  logic             trig_i,
   input  logic [CNT_W-1:0] load_i,
   input  logic             ack_i,
   output logic             req_o,
   output logic             ovr_evt_o
);
   if (CNT_W < 1) begin : g_bad_w
      $error("rg_burst_ctr: CNT_W must be at least 1");
   end

   logic             busy_q;
   logic [CNT_W-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         left_q <= '0;
      end else if (kill_i) begin
         busy_q <= 1'b0;
         left_q <= '0;
      end else if (trig_i && !busy_q) begin
         busy_q <= 1'b1;
         left_q <= load_i;
      end else if (busy_q && ack_i) begin
         if (left_q == '0) busy_q <= 1'b0;
         else              left_q <= left_q - 1'b1;
      end
   end

   assign req_o     = busy_q;
   assign ovr_evt_o = trig_i & busy_q & ~kill_i;
endmodule

// File: rtl/rg_ovr_flag.sv
module rg_ovr_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   logic flag_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_q <= 1'b0;
      else if (set_i) flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
   end
   assign flag_o = flag_q;
endmodule

// File: rtl/dma_trig_reqgen.sv
module dma_trig_reqgen
   import reqgen_pkg::*;
#(
   parameter int CNT_W       = 5,
   parameter int HOLD_CYC    = 3,
   parameter int MASK_CYC    = 3,
   parameter int SYNC_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctrl_we_i,
   input  logic             ctrl_en_i,
   input  logic [CNT_W-1:0] ctrl_cnt_i,
   input  logic [1:0]       ctrl_pol_i,
   input  logic             ctrl_ovr_ie_i,
   input  logic             clr_we_i,
   input  logic             clr_ovr_i,
   input  logic             chan_secure_i,
   input  logic             trig_i,
   output logic             dma_req_o,
   input  logic             dma_ack_i,
   output logic             ovr_flag_o,
   output logic             irq_sec_o,
   output logic             irq_nsec_o
);
   ctrl_bits_t       ctrl_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '{en: 1'b0, ovr_ie: 1'b0, pol: POL_NONE};
         cnt_q  <= '0;
      end else if (ctrl_we_i) begin
         ctrl_q <= '{en: ctrl_en_i, ovr_ie: ctrl_ovr_ie_i, pol: trig_pol_e'(ctrl_pol_i)};
         cnt_q  <= ctrl_cnt_i;
      end
   end

   logic rise, fall, trig_ok, ovr_evt, kill;

   assign kill = ctrl_we_i & ~ctrl_en_i;

   rg_edge_filter #(.SYNC_STAGES(SYNC_STAGES), .HOLD_CYC(HOLD_CYC)) u_filt (
      .clk(clk), .rst_n(rst_n), .lvl_i(trig_i), .rise_o(rise), .fall_o(fall)
   );

   rg_trig_gate #(.MASK_CYC(MASK_CYC)) u_gate (
      .clk(clk), .rst_n(rst_n), .ctrl_we_i(ctrl_we_i), .en_i(ctrl_q.en),
      .pol_i(ctrl_q.pol), .rise_i(rise), .fall_i(fall), .trig_o(trig_ok)
   );

   rg_burst_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .kill_i(kill), .trig_i(trig_ok),
      .load_i(cnt_q), .ack_i(dma_ack_i), .req_o(dma_req_o), .ovr_evt_o(ovr_evt)
   );

   rg_ovr_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set_i(ovr_evt),
      .clr_i(clr_we_i & clr_ovr_i), .flag_o(ovr_flag_o)
   );

   logic irq_any;
   assign irq_any    = ovr_flag_o & ctrl_q.ovr_ie;
   assign irq_sec_o  = irq_any & chan_secure_i;
   assign irq_nsec_o = irq_any & ~chan_secure_i;
endmodule

// File: rtl/dma_trig_reqgen_chk.sv
module dma_trig_reqgen_chk (
   input logic clk,
   input logic rst_n,
   input logic ctrl_we_i,
   input logic ctrl_en_i,
   input logic clr_we_i,
   input logic clr_ovr_i,
   input logic dma_ack_i,
   input logic dma_req_o,
   input logic ovr_flag_o,
   input logic irq_sec_o,
   input logic irq_nsec_o,
   input logic en_state
);
   a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_flag_o && !(clr_we_i && clr_ovr_i) |=> ovr_flag_o);

   a_r5_ovr_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
      !ovr_flag_o |=> (!ovr_flag_o || $past(dma_req_o)));

   a_r4_req_falls_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req_o && !dma_ack_i && !ctrl_we_i |=> dma_req_o);

   a_r8_disable_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_we_i && !ctrl_en_i |=> !dma_req_o);

   a_r3_write_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_we_i && !dma_req_o |=> !dma_req_o);

   a_r9_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      !en_state && !dma_req_o |=> !dma_req_o);

   a_r7_irq_one_line: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({irq_sec_o, irq_nsec_o}));

   a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_sec_o || irq_nsec_o) |-> ovr_flag_o);
endmodule

bind dma_trig_reqgen dma_trig_reqgen_chk u_chk (
   .clk(clk), .rst_n(rst_n), .ctrl_we_i(ctrl_we_i), .ctrl_en_i(ctrl_en_i),
   .clr_we_i(clr_we_i), .clr_ovr_i(clr_ovr_i), .dma_ack_i(dma_ack_i),
   .dma_req_o(dma_req_o), .ovr_flag_o(ovr_flag_o), .irq_sec_o(irq_sec_o),
   .irq_nsec_o(irq_nsec_o), .en_state(ctrl_q.en)
);

// File: tb/dma_trig_reqgen_bench.sv
module dma_trig_reqgen_bench;
   localparam int CNT_W = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctrl_we = 0, ctrl_en = 0, ctrl_ie = 0;
   logic [CNT_W-1:0] ctrl_cnt = '0;
   logic [1:0] ctrl_pol = 2'b00;
   logic clr_we = 0, clr_ovr = 0, sec = 0, trig = 0, ack = 0;
   logic req, flag, irq_s, irq_n;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   dma_trig_reqgen #(.CNT_W(CNT_W)) u_dma_trig_reqgen (
      .clk(clk), .rst_n(rst_n), .ctrl_we_i(ctrl_we), .ctrl_en_i(ctrl_en),
      .ctrl_cnt_i(ctrl_cnt), .ctrl_pol_i(ctrl_pol), .ctrl_ovr_ie_i(ctrl_ie),
      .clr_we_i(clr_we), .clr_ovr_i(clr_ovr), .chan_secure_i(sec),
      .trig_i(trig), .dma_req_o(req), .dma_ack_i(ack), .ovr_flag_o(flag),
      .irq_sec_o(irq_s), .irq_nsec_o(irq_n)
   );

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(logic act, logic exp, string tag);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   task automatic ctrl_write(logic en, int cnt, logic [1:0] pol, logic ie);
      ctrl_we = 1; ctrl_en = en; ctrl_cnt = CNT_W'(cnt); ctrl_pol = pol; ctrl_ie = ie;
      tick(1);
      ctrl_we = 0;
   endtask

   task automatic ack_n(int n);
      ack = 1; tick(n); ack = 0;
   endtask

   task automatic t_reset;
      check(req, 1'b0, "R10 req after reset");
      check(flag, 1'b0, "R10 flag after reset");
      check(irq_s | irq_n, 1'b0, "R10 irq after reset");
   endtask

   task automatic t_filter_burst;
      ctrl_write(1, 2, 2'b01, 0); tick(4);
      trig = 1; tick(2); trig = 0; tick(8);
      check(req, 1'b0, "R1 two-cycle pulse ignored");
      trig = 1; tick(3);
      check(req, 1'b0, "R1 req not yet after 3 edges");
      tick(1);
      check(req, 1'b1, "R1 req on 4th edge");
      ack = 1; tick(2);
      check(req, 1'b1, "R4 req held after 2 of 3 acks");
      tick(1); ack = 0;
      check(req, 1'b0, "R4 req low after N+1 acks");
      trig = 0; tick(8);
      check(req, 1'b0, "R2 falling edge ignored with 01");
   endtask

   task automatic t_polarity;
      ctrl_write(1, 0, 2'b10, 0); tick(4);
      trig = 1; tick(8);
      check(req, 1'b0, "R2 rising ignored with 10");
      trig = 0; tick(4);
      check(req, 1'b1, "R2 falling accepted with 10");
      ack_n(1);
      check(req, 1'b0, "R4 single request for N=0");
      ctrl_write(1, 0, 2'b11, 0); tick(4);
      trig = 1; tick(4);
      check(req, 1'b1, "R2 rising accepted with 11");
      ack_n(1);
      trig = 0; tick(4);
      check(req, 1'b1, "R2 falling accepted with 11");
      ack_n(1);
      ctrl_write(1, 0, 2'b00, 0); tick(4);
      trig = 1; tick(8);
      check(req, 1'b0, "R2 rising ignored with 00");
      trig = 0; tick(8);
      check(req, 1'b0, "R2 falling ignored with 00");
   endtask

   task automatic t_mask;
      ctrl_we = 1; ctrl_en = 1; ctrl_cnt = '0; ctrl_pol = 2'b01; ctrl_ie = 0;
      trig = 1; tick(1); ctrl_we = 0; tick(10);
      check(req, 1'b0, "R3 edge in masked window dropped");
      trig = 0; tick(6);
      ctrl_we = 1; tick(1); ctrl_we = 0;
      trig = 1; tick(3);
      check(req, 1'b0, "R3 req not yet");
      tick(1);
      check(req, 1'b1, "R3 edge just after window accepted");
      ack_n(1);
      trig = 0; tick(4);
   endtask

   task automatic t_overrun;
      sec = 0;
      ctrl_write(1, 1, 2'b01, 1); tick(4);
      trig = 1; tick(4);
      check(req, 1'b1, "R5 burst started");
      trig = 0; tick(4);
      check(flag, 1'b0, "R5 no flag yet");
      trig = 1; tick(4);
      check(flag, 1'b1, "R5 overrun on trigger while pending");
      check(irq_n, 1'b1, "R7 non-secure irq");
      check(irq_s, 1'b0, "R7 secure irq idle");
      ack_n(1);
      check(req, 1'b1, "R5 burst not restarted, 1 ack left");
      ack_n(1);
      check(req, 1'b0, "R5 burst ends after 2 acks");
      sec = 1; tick(1);
      check(irq_s, 1'b1, "R7 secure irq");
      check(irq_n, 1'b0, "R7 non-secure irq idle");
      ctrl_write(1, 1, 2'b01, 0); tick(1);
      check(irq_s | irq_n, 1'b0, "R7 irq off when disabled");
      tick(5);
      check(flag, 1'b1, "R6 flag sticky");
      clr_we = 1; clr_ovr = 1; tick(1); clr_we = 0; clr_ovr = 0;
      check(flag, 1'b0, "R6 write-one clears flag");
      trig = 0; tick(4);
      trig = 1; tick(4);
      trig = 0; tick(4);
      trig = 1; tick(4);
      check(flag, 1'b1, "R6 flag set again");
      trig = 0; tick(4);
      trig = 1; tick(3);
      clr_we = 1; clr_ovr = 1; tick(1); clr_we = 0; clr_ovr = 0;
      check(flag, 1'b1, "R6 set wins over same-cycle clear");
   endtask

   task automatic t_disable;
      check(req, 1'b1, "R8 burst pending before disable");
      ctrl_write(0, 1, 2'b01, 0);
      check(req, 1'b0, "R8 disable drops req");
      check(flag, 1'b1, "R8 flag kept on disable");
      trig = 0; tick(4); trig = 1; tick(8);
      check(req, 1'b0, "R9 no burst while disabled");
      check(flag, 1'b1, "R9 flag unchanged while disabled");
      ctrl_write(1, 1, 2'b01, 0); tick(4);
      trig = 0; tick(4); trig = 1; tick(4);
      check(req, 1'b1, "R8 new burst after re-enable");
      ack_n(1);
      check(req, 1'b1, "R8 counter reloaded, 1 ack left");
      ack_n(1);
      check(req, 1'b0, "R8 burst ends after N+1");
   endtask

   task automatic finish_run;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      tick(3);
      t_reset;
      rst_n = 1; tick(2);
      t_filter_burst;
      t_polarity;
      t_mask;
      t_overrun;
      t_disable;
      done = 1;
      finish_run;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         finish_run;
      end
   end
endmodule